// File: doc/BRIEF.md
# Paged Memory Region Address Decoder

This block sits between a 32-bit CPU bus and a set of memory and register targets. The address space is split into 16 MB pages, with the page number taken from the top eight address bits. For each request the block forces the address into alignment for the access size and picks exactly one target. It also works out the target-local offset, applying the mirroring and folding rules of each region. Finally it builds a byte-lane enable mask and replicates the write data across the lanes.

Writes that a region does not accept are sent to a null target and do not raise the write strobe. Reads that fall outside the readable part of the boot ROM, and all accesses to pages that have no target, are handled the same way. Selection, offset, lane mask, data lanes, write strobe and misalignment warning are all combinational and valid in the cycle of the request. A single registered pulse reports, one cycle later, that an unmapped page was accessed.

Top module: `page_region_decoder`

## Requirements
- R1: While `req_valid` is high, exactly one `tgt_sel` bit is set, chosen from bits [31:24] of the aligned address as follows. Page 0x00 selects boot ROM (bit 0). Page 0x02 selects external work RAM (bit 1) and page 0x03 internal work RAM (bit 2). Page 0x04 selects I/O (bit 3), 0x05 palette RAM (bit 4), 0x06 video RAM (bit 5) and 0x07 object RAM (bit 6). Pages 0x08–0x0D select cartridge (bit 7) and pages 0x0E–0x0F select save RAM (bit 8). Every other case selects the null target (bit 9), and its offset is 0.
- R2: `req_size` encodes byte as 0, halfword as 1 and word as 2; code 3 behaves as word. A word access clears address bits [1:0] before decoding and a halfword access clears bit 0. `misalign_warn` is high exactly when a valid request has any of those cleared bits set.
- R3: `tgt_be` is 4'b0001 shifted left by address bits [1:0] for a byte, 4'b0011 or 4'b1100 for a halfword (chosen by address bit 1), and 4'b1111 for a word.
- R4: `tgt_wdata` repeats byte [7:0] four times for a byte access, repeats [15:0] twice for a halfword access, and passes `req_wdata` unchanged for a word access.
- R5: The external work RAM offset is the aligned address modulo 0x40000. The internal work RAM offset is the aligned address modulo 0x8000.
- R6: The I/O offset is the aligned address modulo 0x800, except that when the low 16 address bits equal 0x8000 the offset is 0x800.
- R7: The palette RAM and object RAM offsets are the aligned address modulo 0x400.
- R8: The video RAM offset is the aligned address modulo 0x20000, reduced by 0x8000 when that value is strictly greater than 0x18000. A value of exactly 0x18000 is kept unchanged.
- R9: A boot ROM page read whose aligned address is below 0x4000 selects boot ROM with offset equal to that address. A read at 0x4000 or above selects the null target, and so does every write to page 0x00.
- R10: Writes to pages 0x08 and 0x09 select the null target. Every other cartridge access has offset equal to aligned address bits [26:0]. A save RAM access has offset equal to aligned address bits [24:0].
- R11: `tgt_write` is high only for a valid write whose selected target is not the null target.
- R12: `unmapped_pulse` is high in the cycle after a valid request to page 0x01 or to any page at or above 0x10, and low after every other cycle and during reset.
- R13: While `req_valid` is low, `tgt_sel`, `tgt_be`, `tgt_write` and `misalign_warn` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_wdata | input | 32 | Write data, low-justified |
| tgt_sel | output | 10 | One-hot target select |
| tgt_offset | output | 27 | Region-local byte offset |
| tgt_be | output | 4 | Byte-lane enables |
| tgt_wdata | output | 32 | Lane-replicated write data |
| tgt_write | output | 1 | Write strobe to the selected target |
| misalign_warn | output | 1 | Request was misaligned for its size |
| unmapped_pulse | output | 1 | Registered flag for an unmapped page |

## Verification
Select, offset, lane mask, data lanes, write strobe and misalignment warning are due in the same cycle as the request. The bench drives each request on a falling edge and samples those outputs 1 ns later, well before the next rising edge. The unmapped flag passes through one register, so the bench reads it 1 ns after the following rising edge and compares it with the request it has just retired. The sweep covers 32 pages, ten low-address patterns chosen at the fold, remap and mirror boundaries, all four size codes, and both directions.

// File: rtl/pgdec_pkg.sv
package pgdec_pkg;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int TGT_COUNT = 10;

  typedef enum logic [3:0] {
    TGT_BOOT = 4'd0,
    TGT_XRAM = 4'd1,
    TGT_IRAM = 4'd2,
    TGT_IOREG = 4'd3,
    TGT_PAL  = 4'd4,
    TGT_VID  = 4'd5,
    TGT_OBJ  = 4'd6,
    TGT_CART = 4'd7,
    TGT_SAVE = 4'd8,
    TGT_NULL = 4'd9
  } tgt_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } size_e;

  // Clear the low address bits that the access size does not permit.
  function automatic logic [ADDR_W-1:0] force_align(input logic [ADDR_W-1:0] a,
                                                     input size_e sz);
    case (sz)
      SZ_BYTE: return a;
      SZ_HALF: return {a[ADDR_W-1:1], 1'b0};
      default: return {a[ADDR_W-1:2], 2'b00};
    endcase
  endfunction

  function automatic logic is_misaligned(input logic [1:0] lo, input size_e sz);
    case (sz)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return lo[0];
      default: return |lo;
    endcase
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] lo, input size_e sz);
    case (sz)
      SZ_BYTE: return LANES'(1) << lo;
      SZ_HALF: return lo[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] lane_data(input logic [DATA_W-1:0] d, input size_e sz);
    case (sz)
      SZ_BYTE: return {LANES{d[7:0]}};
      SZ_HALF: return {(LANES/2){d[15:0]}};
      default: return d;
    endcase
  endfunction

endpackage

// File: rtl/pgdec_align.sv
module pgdec_align
  import pgdec_pkg::*;
(
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] aligned_addr,
  output logic [LANES-1:0]  lane_en,
  output logic [DATA_W-1:0] lane_wdata,
  output logic              misalign
);

  size_e sz;
  assign sz = size_e'(req_size);

  assign aligned_addr = force_align(req_addr, sz);
  assign lane_en      = req_valid ? lane_mask(req_addr[1:0], sz) : '0;
  assign lane_wdata   = lane_data(req_wdata, sz);
  assign misalign     = req_valid && is_misaligned(req_addr[1:0], sz);

endmodule

// File: rtl/pgdec_region.sv
module pgdec_region
  import pgdec_pkg::*;
#(
  parameter int OFS_W          = 27,
  parameter int BOOT_BYTES     = 'h4000,
  parameter int XRAM_BYTES     = 'h40000,
  parameter int IRAM_BYTES     = 'h8000,
  parameter int IO_SPAN        = 'h800,
  parameter int IO_ALIAS_KEY   = 'h8000,
  parameter int SMALL_BYTES    = 'h400,
  parameter int VID_BYTES      = 'h20000,
  parameter int VID_FOLD_LIMIT = 'h18000,
  parameter int VID_FOLD_STEP  = 'h8000,
  parameter int SAVE_SPAN      = 'h2000000
) (
  input  logic [ADDR_W-1:0] aligned_addr,
  input  logic              is_write,
  output tgt_e              tgt,
  output logic [OFS_W-1:0]  offset,
  output logic              unmapped
);

  localparam logic [OFS_W-1:0] XRAM_MASK  = OFS_W'(XRAM_BYTES - 1);
  localparam logic [OFS_W-1:0] IRAM_MASK  = OFS_W'(IRAM_BYTES - 1);
  localparam logic [OFS_W-1:0] IO_MASK    = OFS_W'(IO_SPAN - 1);
  localparam logic [OFS_W-1:0] SMALL_MASK = OFS_W'(SMALL_BYTES - 1);
  localparam logic [OFS_W-1:0] VID_MASK   = OFS_W'(VID_BYTES - 1);
  localparam logic [OFS_W-1:0] SAVE_MASK  = OFS_W'(SAVE_SPAN - 1);

  function automatic logic [OFS_W-1:0] vid_local(input logic [OFS_W-1:0] lo);
    logic [OFS_W-1:0] v;
    v = lo & VID_MASK;
    if (v > OFS_W'(VID_FOLD_LIMIT)) v = v - OFS_W'(VID_FOLD_STEP);
    return v;
  endfunction

  function automatic logic [OFS_W-1:0] io_local(input logic [15:0] key,
                                                input logic [OFS_W-1:0] lo);
    if (key == 16'(IO_ALIAS_KEY)) return OFS_W'(IO_SPAN);
    return lo & IO_MASK;
  endfunction

  logic [7:0]       page;
  logic [OFS_W-1:0] low;
  assign page = aligned_addr[ADDR_W-1 -: 8];
  assign low  = aligned_addr[OFS_W-1:0];

  always_comb begin
    tgt      = TGT_NULL;
    offset   = '0;
    unmapped = 1'b0;
    case (page)
      8'h00: begin
        if (!is_write && low < OFS_W'(BOOT_BYTES)) begin
          tgt    = TGT_BOOT;
          offset = low;
        end
      end
      8'h02: begin tgt = TGT_XRAM;  offset = low & XRAM_MASK; end
      8'h03: begin tgt = TGT_IRAM;  offset = low & IRAM_MASK; end
      8'h04: begin tgt = TGT_IOREG; offset = io_local(aligned_addr[15:0], low); end
      8'h05: begin tgt = TGT_PAL;   offset = low & SMALL_MASK; end
      8'h06: begin tgt = TGT_VID;   offset = vid_local(low); end
      8'h07: begin tgt = TGT_OBJ;   offset = low & SMALL_MASK; end
      8'h08, 8'h09: begin
        if (!is_write) begin
          tgt    = TGT_CART;
          offset = low;
        end
      end
      8'h0A, 8'h0B, 8'h0C, 8'h0D: begin tgt = TGT_CART; offset = low; end
      8'h0E, 8'h0F: begin tgt = TGT_SAVE; offset = low & SAVE_MASK; end
      default: unmapped = 1'b1;
    endcase
  end

endmodule

// File: rtl/pgdec_status.sv
module pgdec_status (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);

  always_ff @(posedge clk) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= fire;
  end

endmodule

// File: rtl/page_region_decoder.sv
module page_region_decoder
  import pgdec_pkg::*;
#(
  parameter int OFS_W          = 27,
  parameter int BOOT_BYTES     = 'h4000,
  parameter int VID_BYTES      = 'h20000,
  parameter int VID_FOLD_LIMIT = 'h18000,
  parameter int VID_FOLD_STEP  = 'h8000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [31:0]          req_addr,
  input  logic                 req_write,
  input  logic [1:0]           req_size,
  input  logic [31:0]          req_wdata,
  output logic [TGT_COUNT-1:0] tgt_sel,
  output logic [OFS_W-1:0]     tgt_offset,
  output logic [3:0]           tgt_be,
  output logic [31:0]          tgt_wdata,
  output logic                 tgt_write,
  output logic                 misalign_warn,
  output logic                 unmapped_pulse
);

  // Named internal events, visible to the bound checker.
  logic [ADDR_W-1:0] aligned_addr;
  tgt_e              dec_tgt;
  logic              dec_unmapped;
  logic              unmapped_fire;

  pgdec_align u_align (
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_size     (req_size),
    .req_wdata    (req_wdata),
    .aligned_addr (aligned_addr),
    .lane_en      (tgt_be),
    .lane_wdata   (tgt_wdata),
    .misalign     (misalign_warn)
  );

  pgdec_region #(
    .OFS_W          (OFS_W),
    .BOOT_BYTES     (BOOT_BYTES),
    .VID_BYTES      (VID_BYTES),
    .VID_FOLD_LIMIT (VID_FOLD_LIMIT),
    .VID_FOLD_STEP  (VID_FOLD_STEP)
  ) u_region (
    .aligned_addr (aligned_addr),
    .is_write     (req_write),
    .tgt          (dec_tgt),
    .offset       (tgt_offset),
    .unmapped     (dec_unmapped)
  );

  for (genvar i = 0; i < TGT_COUNT; i++) begin : g_sel
    assign tgt_sel[i] = req_valid && (dec_tgt == tgt_e'(i));
  end

  assign tgt_write     = req_valid && req_write && (dec_tgt != TGT_NULL);
  assign unmapped_fire = req_valid && dec_unmapped;

  pgdec_status u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (unmapped_fire),
    .pulse (unmapped_pulse)
  );

endmodule

// File: rtl/pgdec_checker.sv
module pgdec_checker
  import pgdec_pkg::*;
#(
  parameter int OFS_W          = 27,
  parameter int BOOT_BYTES     = 'h4000,
  parameter int VID_FOLD_LIMIT = 'h18000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [31:0]          req_addr,
  input logic                 req_write,
  input logic [TGT_COUNT-1:0] tgt_sel,
  input logic [OFS_W-1:0]     tgt_offset,
  input logic [3:0]           tgt_be,
  input logic                 tgt_write,
  input logic                 misalign_warn,
  input logic                 unmapped_pulse
);

  logic hole_page;
  assign hole_page = (req_addr[31:24] == 8'h01) || (req_addr[31:28] != 4'h0);

  a_r1_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones(tgt_sel) == 1);

  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (tgt_sel == '0 && tgt_be == '0 && !tgt_write && !misalign_warn));

  a_r3_lanes_present: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> tgt_be != '0);

  a_r11_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_write |-> (req_write && !tgt_sel[TGT_NULL]));

  a_r9_boot_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel[TGT_BOOT] |-> (!req_write && tgt_offset < OFS_W'(BOOT_BYTES)));

  a_r8_vid_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel[TGT_VID] |-> tgt_offset <= OFS_W'(VID_FOLD_LIMIT));

  a_r10_low_cart_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_write && tgt_sel[TGT_CART]) |-> req_addr[31:25] != 7'b0000100);

  a_r12_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hole_page) |=> unmapped_pulse);

  a_r12_pulse_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && hole_page) |=> !unmapped_pulse);

endmodule

bind page_region_decoder pgdec_checker #(
  .OFS_W          (OFS_W),
  .BOOT_BYTES     (BOOT_BYTES),
  .VID_FOLD_LIMIT (VID_FOLD_LIMIT)
) u_chk (.*);

// File: tb/page_region_decoder_tb.sv
module page_region_decoder_tb;

  localparam time CLK_P = 4ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_wdata = '0;
  logic [9:0]  tgt_sel;
  logic [26:0] tgt_offset;
  logic [3:0]  tgt_be;
  logic [31:0] tgt_wdata;
  logic        tgt_write;
  logic        misalign_warn;
  logic        unmapped_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  page_region_decoder u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h wr=%0d sz=%0d actual=%h expected=%h",
               tag, req_addr, req_write, req_size, act, exp);
    end
  endtask

  // Target indices: 0 boot,1 xram,2 iram,3 io,4 pal,5 vid,6 obj,7 cart,8 save,9 null
  task automatic model(input logic [31:0] al, input bit w,
                       output int idx, output logic [31:0] ofs, output bit hole,
                       output string tag);
    int unsigned p;
    p = al / 32'h0100_0000;
    idx = 9; ofs = 0; hole = 0; tag = "R11";
    if (p == 0) begin
      tag = "R9";
      if (!w && al < 32'h4000) begin idx = 0; ofs = al; end
    end else if (p == 2) begin tag = "R5"; idx = 1; ofs = al % 32'h40000; end
    else if (p == 3) begin tag = "R5"; idx = 2; ofs = al % 32'h8000; end
    else if (p == 4) begin
      tag = "R6"; idx = 3;
      ofs = ((al % 32'h10000) == 32'h8000) ? 32'h800 : al % 32'h800;
    end
    else if (p == 5 || p == 7) begin tag = "R7"; idx = (p == 5) ? 4 : 6; ofs = al % 32'h400; end
    else if (p == 6) begin
      tag = "R8"; idx = 5; ofs = al % 32'h20000;
      if (ofs > 32'h18000) ofs = ofs - 32'h8000;
    end
    else if (p >= 8 && p <= 13) begin
      tag = "R10";
      if (!(w && p <= 9)) begin idx = 7; ofs = al - 32'h0800_0000; end
    end
    else if (p == 14 || p == 15) begin tag = "R10"; idx = 8; ofs = al - 32'h0E00_0000; end
    else hole = 1;
  endtask

  task automatic run_one(input logic [31:0] a, input bit w, input logic [1:0] sz,
                         input logic [31:0] d);
    int unsigned step;
    logic [31:0] al, ofs, exp_be, exp_wd;
    int idx;
    bit hole;
    string tag;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_size = sz; req_wdata = d;
    step = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    al = a - (a % step);
    model(al, w, idx, ofs, hole, tag);
    exp_be = (step == 1) ? (32'd1 << (a % 4)) : (step == 2) ? (((a % 4) >= 2) ? 32'hC : 32'h3) : 32'hF;
    exp_wd = (step == 1) ? d[7:0] * 32'h0101_0101 : (step == 2) ? d[15:0] * 32'h0001_0001 : d;
    #1;
    chk("R1 sel", {22'd0, tgt_sel}, 32'd1 << idx);
    chk({tag, " offset"}, {5'd0, tgt_offset}, ofs);
    chk("R2 warn", {31'd0, misalign_warn}, {31'd0, (a % step) != 0});
    chk("R3 be", {28'd0, tgt_be}, exp_be);
    chk("R4 wdata", tgt_wdata, exp_wd);
    chk("R11 write", {31'd0, tgt_write}, {31'd0, w && idx != 9});
    @(posedge clk); #1;
    chk("R12 pulse", {31'd0, unmapped_pulse}, {31'd0, hole});
  endtask

  initial begin
    logic [31:0] lows [10];
    lows = '{32'h000000, 32'h000003, 32'h003FFF, 32'h004000, 32'h008000,
             32'h018000, 32'h018001, 32'h01FFFE, 32'h0407FD, 32'hFF8000};
    // Reset: an unmapped request during reset must not raise the pulse (R12).
    req_valid = 1'b1; req_addr = 32'h0100_0000;
    repeat (3) @(posedge clk);
    #1 chk("R12 reset", {31'd0, unmapped_pulse}, 32'd0);
    @(negedge clk);
    req_valid = 1'b0; rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R12 idle after reset", {31'd0, unmapped_pulse}, 32'd0);
    // Idle with an unmapped write on the bus (R13).
    @(negedge clk);
    req_addr = 32'h0100_0003; req_write = 1'b1; req_size = 2'd2;
    #1;
    chk("R13 sel", {22'd0, tgt_sel}, 32'd0);
    chk("R13 be", {28'd0, tgt_be}, 32'd0);
    chk("R13 write", {31'd0, tgt_write}, 32'd0);
    chk("R13 warn", {31'd0, misalign_warn}, 32'd0);
    @(posedge clk); #1;
    chk("R12 idle unmapped", {31'd0, unmapped_pulse}, 32'd0);
    // Sweep pages, boundary offsets, size codes and direction.
    for (int pg = 0; pg < 32; pg++)
      for (int k = 0; k < 10; k++)
        for (int sz = 0; sz < 4; sz++)
          for (int w = 0; w < 2; w++)
            run_one({pg[7:0], lows[k][23:0]}, w[0], sz[1:0],
                    32'hA5C3_0000 ^ {pg[7:0], 8'(k), 8'(sz), 8'(w)} ^ 32'h1234_5678);
    // Back to idle: the pulse must drop (R12, R13).
    @(negedge clk);
    req_valid = 1'b0;
    #1 chk("R13 sel end", {22'd0, tgt_sel}, 32'd0);
    @(posedge clk); #1;
    chk("R12 drop", {31'd0, unmapped_pulse}, 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule